// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers the interrupt sources of a multi-slot conversion engine: one ready flag per result slot, plus two error events, a result overwrite and a conversion-time overflow. Each source has its own enable bit. Out of the enabled pending sources, the block reports the single most urgent one as an even-valued vector word and raises a request line whenever that word is nonzero.

A slot flag is set when the engine loads a result into that slot. It is cleared when the slot's result is read, or when software writes the flag word. The two error sources latch a pending bit that is cleared by reading the vector, but only while that source is the one being reported. Reading the vector never touches slot flags. The vector is decoded combinationally from registered state, so it follows a strobe in the cycle after the clock edge that registers it.

Top module: `irq_vector_gen`

## Requirements
- R1: After synchronous reset, all slot flags, error pending bits and enable bits are zero, `vec_out` is 0 and `irq_out` is low.
- R2: A result write (`res_wr_valid` with slot index k) sets flag k. With its enable set, the flag is visible on `vec_out` one clock edge later.
- R3: A slot read (`slot_rd_valid` with slot index k) clears flag k and leaves every other flag as it was.
- R4: `flag_wr` loads the whole slot flag word from `flag_wr_data`, where bit k is slot k. Writing a zero bit clears that flag.
- R5: Precedence within one cycle, for the same slot: a result write beats a slot read, and a slot read beats a software flag write. For an error source, a new event beats a vector-read clear.
- R6: A pulse on `ovw_evt` or `tov_evt` latches the matching pending bit, and the bit stays set until it is cleared by a vector read.
- R7: Encoding: 0x000 means nothing is pending, 0x002 is result overwrite, 0x004 is conversion-time overflow, and slot k is 0x006 + 2*k, so slot 15 is 0x024.
- R8: Priority from highest to lowest: overwrite, then time overflow, then slot 0, slot 1, and so on up to slot 15.
- R9: `en_wr` loads the enables. `en_wr_err` bit 0 enables overwrite and bit 1 enables time overflow; `en_wr_slot` bit k enables slot k. A disabled source is never reported, but its pending state is kept and it appears once it is enabled.
- R10: A vector read (`vec_rd`) clears the error pending bit only if `vec_out` reports that error in the same cycle. It leaves slot flags and any unreported error unchanged.
- R11: `irq_out` is high exactly when `vec_out` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_wr_valid | input | 1 | Result loaded into a slot this cycle |
| res_wr_slot | input | 4 | Slot index of the result write |
| slot_rd_valid | input | 1 | Slot result read this cycle |
| slot_rd_slot | input | 4 | Slot index of the read |
| ovw_evt | input | 1 | Result overwrite event pulse |
| tov_evt | input | 1 | Conversion-time overflow event pulse |
| flag_wr | input | 1 | Software write of the slot flag word |
| flag_wr_data | input | 16 | New slot flag word |
| en_wr | input | 1 | Software write of the enables |
| en_wr_err | input | 2 | Error enables (bit 0 overwrite, bit 1 time overflow) |
| en_wr_slot | input | 16 | Slot enables |
| vec_rd | input | 1 | Vector read strobe |
| vec_out | output | 16 | Encoded vector of the highest-priority enabled pending source |
| irq_out | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that a result write sets its flag and that a slot read clears it unless a write to the same slot wins. They also check that error events latch, that an acknowledge clears the pending bit when no new event arrives, that the vector is zero right after reset, and that it stays zero while every enable is off. The bench scenarios are what show the behaviour visible at the ports: the exact vector codes, the priority order across simultaneous sources, that masked sources are retained, and that a vector read clears only the error it reported. The bench checks these against a reference model fed with random strobes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int VEC_W  = 16;
    localparam int ERR_N  = 2;
    localparam int ERR_OVW = 0;
    localparam int ERR_TOV = 1;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_OVERWRITE = 2'd1,
        SRC_TIME_OVF = 2'd2,
        SRC_SLOT     = 2'd3
    } src_kind_e;

    typedef struct packed {
        src_kind_e  kind;
        logic [7:0] slot;
    } winner_t;

    // Even-step vector: 2 = overwrite, 4 = time overflow, 6 + 2k = slot k
    function automatic logic [VEC_W-1:0] encode_vec(input winner_t w);
        logic [VEC_W-1:0] v;
        case (w.kind)
            SRC_OVERWRITE: v = VEC_W'(2);
            SRC_TIME_OVF:  v = VEC_W'(4);
            SRC_SLOT:      v = VEC_W'(6) + VEC_W'({w.slot, 1'b0});
            default:       v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irqv_slot_flags.sv
module irqv_slot_flags #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_v,
    input  logic [SLOT_W-1:0]    set_slot,
    input  logic                 clr_v,
    input  logic [SLOT_W-1:0]    clr_slot,
    input  logic                 sw_wr,
    input  logic [NUM_SLOTS-1:0] sw_data,
    output logic [NUM_SLOTS-1:0] flags_o
);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_flag
        logic hit_set, hit_clr;
        assign hit_set = set_v && (set_slot == SLOT_W'(k));
        assign hit_clr = clr_v && (clr_slot == SLOT_W'(k));
        always_ff @(posedge clk) begin
            if (rst)          flags_o[k] <= 1'b0;
            else if (hit_set) flags_o[k] <= 1'b1;
            else if (hit_clr) flags_o[k] <= 1'b0;
            else if (sw_wr)   flags_o[k] <= sw_data[k];
        end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        set_v |=> flags_o[$past(set_slot)]);

    // R5: a same-slot write wins, so only check clear without it
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_v && !(set_v && set_slot == clr_slot)) |=> !flags_o[$past(clr_slot)]);

endmodule

// File: rtl/irqv_err_pend.sv
module irqv_err_pend (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ack,
    output logic pend_o
);

    always_ff @(posedge clk) begin
        if (rst)      pend_o <= 1'b0;
        else if (evt) pend_o <= 1'b1;
        else if (ack) pend_o <= 1'b0;
    end

    assert_evt_latch_R6: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend_o);

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt) |=> !pend_o);

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import irqv_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic [ERR_N-1:0]     err_req,
    input  logic [NUM_SLOTS-1:0] slot_req,
    output winner_t              win_o
);

    always_comb begin
        win_o = '{kind: SRC_NONE, slot: 8'd0};
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (slot_req[k]) win_o = '{kind: SRC_SLOT, slot: 8'(k)};
        end
        if (err_req[ERR_TOV]) win_o = '{kind: SRC_TIME_OVF, slot: 8'd0};
        if (err_req[ERR_OVW]) win_o = '{kind: SRC_OVERWRITE, slot: 8'd0};
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irqv_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 res_wr_valid,
    input  logic [SLOT_W-1:0]    res_wr_slot,
    input  logic                 slot_rd_valid,
    input  logic [SLOT_W-1:0]    slot_rd_slot,
    input  logic                 ovw_evt,
    input  logic                 tov_evt,
    input  logic                 flag_wr,
    input  logic [NUM_SLOTS-1:0] flag_wr_data,
    input  logic                 en_wr,
    input  logic [ERR_N-1:0]     en_wr_err,
    input  logic [NUM_SLOTS-1:0] en_wr_slot,
    input  logic                 vec_rd,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 irq_out
);

    logic [NUM_SLOTS-1:0] flags_q;
    logic [NUM_SLOTS-1:0] en_slot_q;
    logic [ERR_N-1:0]     en_err_q;
    logic [ERR_N-1:0]     err_pend;
    logic [ERR_N-1:0]     err_evt;
    logic [ERR_N-1:0]     err_ack;
    winner_t              win;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_slot_q <= '0;
            en_err_q  <= '0;
        end else if (en_wr) begin
            en_slot_q <= en_wr_slot;
            en_err_q  <= en_wr_err;
        end
    end

    irqv_slot_flags #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_v    (res_wr_valid),
        .set_slot (res_wr_slot),
        .clr_v    (slot_rd_valid),
        .clr_slot (slot_rd_slot),
        .sw_wr    (flag_wr),
        .sw_data  (flag_wr_data),
        .flags_o  (flags_q)
    );

    assign err_evt[ERR_OVW] = ovw_evt;
    assign err_evt[ERR_TOV] = tov_evt;
    assign err_ack[ERR_OVW] = vec_rd && (win.kind == SRC_OVERWRITE);
    assign err_ack[ERR_TOV] = vec_rd && (win.kind == SRC_TIME_OVF);

    for (genvar e = 0; e < ERR_N; e++) begin : g_err
        irqv_err_pend u_pend (
            .clk    (clk),
            .rst    (rst),
            .evt    (err_evt[e]),
            .ack    (err_ack[e]),
            .pend_o (err_pend[e])
        );
    end

    irqv_prio_enc #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
        .err_req  (err_pend & en_err_q),
        .slot_req (flags_q & en_slot_q),
        .win_o    (win)
    );

    assign vec_out = encode_vec(win);
    assign irq_out = (vec_out != '0);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vec_out == '0 && !irq_out));

    assert_masked_off_R9: assert property (@(posedge clk) disable iff (rst)
        (en_err_q == '0 && en_slot_q == '0) |-> (vec_out == '0));

    assert_even_R7: assert property (@(posedge clk) disable iff (rst)
        !vec_out[0]);

endmodule

// File: tb/irq_vector_gen_tb_top.sv
`timescale 1ns/1ps
module irq_vector_gen_tb_top;

    localparam int N  = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          res_wr_valid, slot_rd_valid, ovw_evt, tov_evt;
    logic [SW-1:0] res_wr_slot, slot_rd_slot;
    logic          flag_wr, en_wr, vec_rd;
    logic [N-1:0]  flag_wr_data, en_wr_slot;
    logic [1:0]    en_wr_err;
    logic [15:0]   vec_out;
    logic          irq_out;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [N-1:0] m_flags, m_en;
    logic [1:0]   m_pend, m_enerr;

    always #4 clk = ~clk;

    irq_vector_gen #(.NUM_SLOTS(N)) dut_i (
        .clk(clk), .rst(rst),
        .res_wr_valid(res_wr_valid), .res_wr_slot(res_wr_slot),
        .slot_rd_valid(slot_rd_valid), .slot_rd_slot(slot_rd_slot),
        .ovw_evt(ovw_evt), .tov_evt(tov_evt),
        .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
        .en_wr(en_wr), .en_wr_err(en_wr_err), .en_wr_slot(en_wr_slot),
        .vec_rd(vec_rd), .vec_out(vec_out), .irq_out(irq_out)
    );

    function automatic logic [15:0] ref_vec(logic [N-1:0] f, logic [N-1:0] e,
                                            logic [1:0] p, logic [1:0] pe);
        if (p[0] && pe[0]) return 16'h002;
        if (p[1] && pe[1]) return 16'h004;
        for (int k = 0; k < N; k++)
            if (f[k] && e[k]) return 16'(6 + 2 * k);
        return 16'h000;
    endfunction

    task automatic idle();
        res_wr_valid = 0; res_wr_slot = '0; slot_rd_valid = 0; slot_rd_slot = '0;
        ovw_evt = 0; tov_evt = 0; flag_wr = 0; flag_wr_data = '0;
        en_wr = 0; en_wr_err = '0; en_wr_slot = '0; vec_rd = 0;
    endtask

    // advance one clock, updating the reference from the applied inputs
    task automatic tick();
        logic [N-1:0] nf;
        logic [1:0]   np;
        logic [15:0]  cur;
        cur = ref_vec(m_flags, m_en, m_pend, m_enerr);
        nf = m_flags;
        np = m_pend;
        for (int k = 0; k < N; k++) begin
            if (res_wr_valid && res_wr_slot == SW'(k))       nf[k] = 1'b1;
            else if (slot_rd_valid && slot_rd_slot == SW'(k)) nf[k] = 1'b0;
            else if (flag_wr)                                nf[k] = flag_wr_data[k];
        end
        if (ovw_evt) np[0] = 1'b1; else if (vec_rd && cur == 16'h002) np[0] = 1'b0;
        if (tov_evt) np[1] = 1'b1; else if (vec_rd && cur == 16'h004) np[1] = 1'b0;
        @(posedge clk);
        if (rst) begin
            m_flags = '0; m_en = '0; m_pend = '0; m_enerr = '0;
        end else begin
            m_flags = nf; m_pend = np;
            if (en_wr) begin m_en = en_wr_slot; m_enerr = en_wr_err; end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic chk(string tag, logic [15:0] exp);
        checks++;
        if (vec_out !== exp || irq_out !== (exp != 0)) begin
            errors++;
            $display("FAIL %s: vec=%h irq=%b expected vec=%h irq=%b",
                     tag, vec_out, irq_out, exp, exp != 0);
        end
    endtask

    task automatic chk_model(string tag);
        chk(tag, ref_vec(m_flags, m_en, m_pend, m_enerr));
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a3c1));
        m_flags = '0; m_en = '0; m_pend = '0; m_enerr = '0;
        idle();
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        chk("R1 reset", 16'h000);

        en_wr = 1; en_wr_err = 2'b11; en_wr_slot = '1; tick();
        chk("R1 enables alone give no vector", 16'h000);

        res_wr_valid = 1; res_wr_slot = 4'd5; tick();
        chk("R2 slot 5 set, R7 code", 16'h010);
        res_wr_valid = 1; res_wr_slot = 4'd15; tick();
        chk("R8 slot 5 beats slot 15", 16'h010);
        slot_rd_valid = 1; slot_rd_slot = 4'd5; tick();
        chk("R3 read slot 5 leaves slot 15, R7 code 0x24", 16'h024);
        slot_rd_valid = 1; slot_rd_slot = 4'd15; tick();
        chk("R3 read slot 15", 16'h000);

        flag_wr = 1; flag_wr_data = 16'h0003; tick();
        chk("R4 software write sets slot 0", 16'h006);
        flag_wr = 1; flag_wr_data = 16'h0000; tick();
        chk("R4 software write zero clears", 16'h000);

        res_wr_valid = 1; res_wr_slot = 4'd3; tick();
        tov_evt = 1; tick();
        chk("R6 time overflow latched", 16'h004);
        ovw_evt = 1; tick();
        chk("R8 overwrite highest", 16'h002);
        vec_rd = 1; tick();
        chk("R10 read clears overwrite only", 16'h004);
        vec_rd = 1; tick();
        chk("R10 read clears time overflow", 16'h00C);
        vec_rd = 1; tick();
        chk("R10 vector read keeps slot flag", 16'h00C);

        tov_evt = 1; vec_rd = 1; tick();
        vec_rd = 1; tov_evt = 1; tick();
        chk("R5 event beats vector-read clear", 16'h004);
        vec_rd = 1; tick();

        res_wr_valid = 1; res_wr_slot = 4'd7; slot_rd_valid = 1; slot_rd_slot = 4'd7; tick();
        slot_rd_valid = 1; slot_rd_slot = 4'd3; tick();
        chk("R5 write beats read on slot 7", 16'h014);
        slot_rd_valid = 1; slot_rd_slot = 4'd7; flag_wr = 1; flag_wr_data = 16'h0080; tick();
        chk("R5 read beats software write", 16'h000);

        en_wr = 1; en_wr_err = 2'b10; en_wr_slot = 16'hFFFB; tick();
        res_wr_valid = 1; res_wr_slot = 4'd2; ovw_evt = 1; tick();
        chk("R9 masked slot 2 and overwrite hidden", 16'h000);
        vec_rd = 1; tick();
        en_wr = 1; en_wr_err = 2'b11; en_wr_slot = '1; tick();
        chk("R9 overwrite retained and shown, R10 unreported kept", 16'h002);
        vec_rd = 1; tick();
        chk("R9 slot 2 retained", 16'h00A);

        rst = 1; tick(); rst = 0;
        chk("R1 reset again", 16'h000);

        for (int i = 0; i < 4000; i++) begin
            res_wr_valid  = ($urandom % 4) == 0;
            res_wr_slot   = SW'($urandom);
            slot_rd_valid = ($urandom % 3) == 0;
            slot_rd_slot  = SW'($urandom);
            ovw_evt       = ($urandom % 16) == 0;
            tov_evt       = ($urandom % 12) == 0;
            flag_wr       = ($urandom % 20) == 0;
            flag_wr_data  = N'($urandom);
            en_wr         = ($urandom % 25) == 0;
            en_wr_err     = 2'($urandom);
            en_wr_slot    = N'($urandom);
            vec_rd        = ($urandom % 3) == 0;
            tick();
            chk_model("R8 R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule